// File: doc/BRIEF.md
# Instruction-Fetch Page-In Trap Controller

This block watches a Z80-style memory bus: address, data, and the active-low M1, MREQ and RD strobes. It keeps a single page-in latch. While the latch is set, the peripheral's own flash, SRAM and device memory replace the host ROM in the lowest 16K of the address space. The latch is set by opcode fetches at a few fixed trap addresses, each gated by a condition supplied from outside. It is also set by a CALL instruction whose target falls in a small gateway window, or directly by a control bit. An opcode fetch at the page-out address clears it.

Every bus event is sampled on the system clock. An address trap takes effect only when the fetch ends, which is when MREQ is seen released. The trap is judged on the address that was present in the last sampled cycle of that fetch, so a bus that is still settling early in the cycle cannot cause a page-in.

The block also drives the downstream A15 line of a peripheral daisy chain. While the block is paged in, or while a deny bit is set, any access below 0x4000 appears upstream as an upper-RAM access. Chained peripherals therefore keep their ROMs off the bus.

The CALL sequencer has three named states:
- `CS_IDLE`: waiting for an opcode.
- `CS_OPCODE`: the 0xCD opcode has been seen.
- `CS_LOW`: the low operand byte has been captured.

Its transitions are:
- The end of an opcode fetch moves it to `CS_OPCODE` if the fetched byte was 0xCD. Otherwise it moves to `CS_IDLE`, which is the abort path from any state.
- The end of an operand read moves it from `CS_OPCODE` to `CS_LOW`.
- The end of an operand read moves it from `CS_LOW` back to `CS_IDLE`. On this transition it raises the gateway hit when the assembled target is in range.

Top module: `ptrap_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `paged_in` is 0 and the CALL sequencer is idle. Two operand reads supplying 0xF8 and then 0x3F without a preceding 0xCD fetch leave `paged_in` at 0.
- R2: An opcode fetch (M1 and MREQ both low) at 0x0000 sets `paged_in` only when `cond_boot` is 1.
- R3: An opcode fetch at 0x0008 sets `paged_in` only when `cond_ext` is 1.
- R4: An opcode fetch at 0x0066 sets `paged_in` only when `cond_nmi` is 1. Each of R2 to R4 is independent of the other two condition inputs.
- R5: An opcode fetch of byte 0xCD, followed by two non-M1 memory reads supplying the low and then the high target byte, sets `paged_in` exactly when the target lies from 0x3FF8 to 0x3FFF inclusive.
- R6: An opcode fetch between the 0xCD fetch and the high operand read aborts the CALL sequence. The remaining reads then leave `paged_in` at 0.
- R7: A trap uses the address in the last sampled cycle before MREQ is released. A fetch that starts at a trap address and moves to a non-trap address before release does not page in.
- R8: An opcode fetch at 0x007C clears `paged_in` at the end of that fetch. `paged_in` stays 1 while that fetch is still active.
- R9: `force_page` at 1 on a clock edge sets `paged_in`.
- R10: `a15_down` equals `addr[15]`, except that it is forced to 1 when `addr[15:14]` is 00 and either `paged_in` or `deny_a15` is 1.
- R11: `paged_in` changes on the first clock edge after the edge that samples the end of the fetch or read. A plain memory read (M1 high) at an armed trap address does not page in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Host address bus |
| data | input | 8 | Host data bus, as seen during reads |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| cond_boot | input | 1 | Arms the trap at 0x0000 |
| cond_ext | input | 1 | Arms the trap at 0x0008 |
| cond_nmi | input | 1 | Arms the trap at 0x0066 (the pending NMI belongs to this peripheral) |
| force_page | input | 1 | Control bit that sets the page-in latch |
| deny_a15 | input | 1 | Control bit that forces downstream A15 for low accesses |
| paged_in | output | 1 | Page-in latch |
| a15_down | output | 1 | A15 passed to downstream peripherals |

## Verification
`paged_in` is registered. It is due one clock edge after the edge that first samples MREQ released. The bench therefore performs each fetch or read across whole negedge-to-negedge cycles and samples at the negedge that follows the release edge. To check R8, it also samples at the negedge while the page-out fetch is still active. `a15_down` is combinational on the address and the latch, so it is sampled half a cycle after the address is driven. `force_page` is checked one edge after it is raised.

// File: rtl/ptrap_pkg.sv
package ptrap_pkg;
    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_OPCODE = 2'd1,
        CS_LOW    = 2'd2
    } call_state_t;

    localparam logic [7:0] CALL_OPCODE = 8'hCD;
endpackage

// File: rtl/ptrap_decode.sv
module ptrap_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 'h0000,
    parameter logic [ADDR_W-1:0] EXT_ADDR  = 'h0008,
    parameter logic [ADDR_W-1:0] NMI_ADDR  = 'h0066,
    parameter logic [ADDR_W-1:0] OUT_ADDR  = 'h007C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cond_boot,
    input  logic              cond_ext,
    input  logic              cond_nmi,
    output logic              in_hit,
    output logic              out_hit
);
    localparam int NTRAP = 3;

    logic [ADDR_W-1:0] trap_addr [NTRAP];
    logic [NTRAP-1:0]  trap_arm;
    logic [NTRAP-1:0]  trap_sel;

    assign trap_addr[0] = BOOT_ADDR;
    assign trap_addr[1] = EXT_ADDR;
    assign trap_addr[2] = NMI_ADDR;
    assign trap_arm     = {cond_nmi, cond_ext, cond_boot};

    for (genvar i = 0; i < NTRAP; i++) begin : g_trap
        assign trap_sel[i] = trap_arm[i] && (addr == trap_addr[i]);
    end

    assign in_hit  = |trap_sel;
    assign out_hit = (addr == OUT_ADDR);
endmodule

// File: rtl/ptrap_call_seq.sv
module ptrap_call_seq
    import ptrap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [2*DATA_W-1:0] GATE_LO = 'h3FF8,
    parameter logic [2*DATA_W-1:0] GATE_HI = 'h3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_fetch,
    input  logic              end_read,
    input  logic [DATA_W-1:0] byte_q,
    output logic              call_hit
);
    localparam int TGT_W = 2 * DATA_W;

    call_state_t       state, state_nx;
    logic [DATA_W-1:0] lo_q;
    logic [TGT_W-1:0]  target;

    assign target = {byte_q, lo_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_IDLE;
            lo_q  <= '0;
        end else begin
            state <= state_nx;
            if (state == CS_OPCODE && end_read) lo_q <= byte_q;
        end
    end

    always_comb begin
        state_nx = state;
        call_hit = 1'b0;
        if (end_fetch) begin
            state_nx = (byte_q == CALL_OPCODE) ? CS_OPCODE : CS_IDLE;
        end else if (end_read) begin
            unique case (state)
                CS_IDLE:   state_nx = CS_IDLE;
                CS_OPCODE: state_nx = CS_LOW;
                CS_LOW: begin
                    state_nx = CS_IDLE;
                    call_hit = (target >= GATE_LO) && (target <= GATE_HI);
                end
                default:   state_nx = CS_IDLE;
            endcase
        end
    end

    assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_fetch && byte_q != CALL_OPCODE) |=> state == CS_IDLE);

    assert_gate_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        call_hit |-> (state == CS_LOW && end_read));
endmodule

// File: rtl/ptrap_top.sv
module ptrap_top #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              m1_n,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              cond_boot,
    input  logic              cond_ext,
    input  logic              cond_nmi,
    input  logic              force_page,
    input  logic              deny_a15,
    output logic              paged_in,
    output logic              a15_down
);
    localparam int TOP = ADDR_W - 1;

    logic fetch_act, read_act;
    logic fetch_q, read_q, hit_q, out_q;
    logic [DATA_W-1:0] byte_q;
    logic end_fetch, end_read;
    logic in_hit, out_hit, call_hit;
    logic paged_q, paged_nx;

    assign fetch_act = !m1_n && !mreq_n;
    assign read_act  = m1_n && !mreq_n && !rd_n;

    ptrap_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (addr),
        .cond_boot (cond_boot),
        .cond_ext  (cond_ext),
        .cond_nmi  (cond_nmi),
        .in_hit    (in_hit),
        .out_hit   (out_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= 1'b0;
            read_q  <= 1'b0;
            hit_q   <= 1'b0;
            out_q   <= 1'b0;
            byte_q  <= '0;
        end else begin
            fetch_q <= fetch_act;
            read_q  <= read_act;
            if (fetch_act) begin
                hit_q <= in_hit;
                out_q <= out_hit;
            end
            if (fetch_act || read_act) byte_q <= data;
        end
    end

    assign end_fetch = fetch_q && !fetch_act;
    assign end_read  = read_q && !read_act;

    ptrap_call_seq #(.DATA_W(DATA_W)) u_call (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_fetch (end_fetch),
        .end_read  (end_read),
        .byte_q    (byte_q),
        .call_hit  (call_hit)
    );

    always_comb begin
        paged_nx = paged_q;
        if (end_fetch && hit_q) paged_nx = 1'b1;
        if (call_hit)           paged_nx = 1'b1;
        if (end_fetch && out_q) paged_nx = 1'b0;
        if (force_page)         paged_nx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) paged_q <= 1'b0;
        else        paged_q <= paged_nx;
    end

    assign paged_in = paged_q;
    assign a15_down = addr[TOP] ||
                      ((addr[TOP:TOP-1] == 2'b00) && (paged_q || deny_a15));

    assert_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paged_q) |-> $past(force_page || end_fetch || end_read));

    assert_pageout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_fetch && out_q && !force_page) |=> !paged_in);

    assert_hold_during_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_act && fetch_q && !force_page) |=> $stable(paged_in));

    assert_low_a15_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (paged_in && addr[TOP:TOP-1] == 2'b00) |-> a15_down);
endmodule

// File: tb/sim_ptrap_top.sv
`timescale 1ns/1ps
module sim_ptrap_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] addr = 16'h8000;
    logic [7:0]  data = 8'h00;
    logic m1_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1;
    logic cond_boot = 1'b0, cond_ext = 1'b0, cond_nmi = 1'b0;
    logic force_page = 1'b0, deny_a15 = 1'b0;
    logic paged_in, a15_down;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ptrap_top u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data(data),
        .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n),
        .cond_boot(cond_boot), .cond_ext(cond_ext), .cond_nmi(cond_nmi),
        .force_page(force_page), .deny_a15(deny_a15),
        .paged_in(paged_in), .a15_down(a15_down)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fetch(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; data = d; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; addr = 16'h8000;
        @(negedge clk);
    endtask

    task automatic mread(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; data = d; m1_n = 1'b1; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        mreq_n = 1'b1; rd_n = 1'b1; addr = 16'h8000;
        @(negedge clk);
    endtask

    task automatic set_paged();
        @(negedge clk);
        force_page = 1'b1;
        @(negedge clk);
        force_page = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state and idle sequencer
        repeat (2) @(negedge clk);
        chk(paged_in, 1'b0, "R1 in reset");
        do_reset();
        chk(paged_in, 1'b0, "R1 after reset");
        mread(16'h8001, 8'hF8);
        mread(16'h8002, 8'h3F);
        chk(paged_in, 1'b0, "R1 idle sequencer");

        // R2/R3/R4: sweep every condition combination on each trap
        for (int t = 0; t < 3; t++) begin
            for (int c = 0; c < 8; c++) begin
                logic [15:0] ta;
                logic exp;
                do_reset();
                cond_boot = c[0]; cond_ext = c[1]; cond_nmi = c[2];
                ta  = (t == 0) ? 16'h0000 : (t == 1) ? 16'h0008 : 16'h0066;
                exp = c[t];
                fetch(ta, 8'h00);
                chk(paged_in, exp, (t == 0) ? "R2" : (t == 1) ? "R3" : "R4");
            end
        end

        // R11: plain read at armed trap address
        do_reset();
        cond_boot = 1'b1; cond_ext = 1'b1; cond_nmi = 1'b1;
        mread(16'h0008, 8'h00);
        chk(paged_in, 1'b0, "R11 plain read");
        // R11: timing, no change on the release edge itself
        @(negedge clk);
        addr = 16'h0066; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; addr = 16'h8000;
        #1;
        chk(paged_in, 1'b0, "R11 not before release edge");
        @(negedge clk);
        chk(paged_in, 1'b1, "R11 one edge after release");

        // R7: address moves away before release
        do_reset();
        @(negedge clk);
        addr = 16'h0008; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        addr = 16'h1234;
        @(negedge clk);
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; addr = 16'h8000;
        @(negedge clk);
        chk(paged_in, 1'b0, "R7 unsettled");
        // R7: settles onto trap address by release
        @(negedge clk);
        addr = 16'h1234; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        addr = 16'h0008;
        @(negedge clk);
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; addr = 16'h8000;
        @(negedge clk);
        chk(paged_in, 1'b1, "R7 settled");
        cond_boot = 1'b0; cond_ext = 1'b0; cond_nmi = 1'b0;

        // R5: CALL target sweep around the gateway window
        for (int tg = 16'h3FF0; tg <= 16'h4007; tg++) begin
            logic [15:0] tv;
            tv = tg[15:0];
            do_reset();
            fetch(16'h8000, 8'hCD);
            mread(16'h8001, tv[7:0]);
            mread(16'h8002, tv[15:8]);
            chk(paged_in, (tv >= 16'h3FF8 && tv <= 16'h3FFF), "R5");
        end
        // R5: non-CALL opcode with in-range operands
        do_reset();
        fetch(16'h8000, 8'hC3);
        mread(16'h8001, 8'hF8);
        mread(16'h8002, 8'h3F);
        chk(paged_in, 1'b0, "R5 other opcode");

        // R6: intervening fetch aborts
        do_reset();
        fetch(16'h8000, 8'hCD);
        mread(16'h8001, 8'hFC);
        fetch(16'h8003, 8'h00);
        mread(16'h8004, 8'h3F);
        chk(paged_in, 1'b0, "R6 abort after low");
        do_reset();
        fetch(16'h8000, 8'hCD);
        fetch(16'h8001, 8'h00);
        mread(16'h8002, 8'hF8);
        mread(16'h8003, 8'h3F);
        chk(paged_in, 1'b0, "R6 abort after opcode");

        // R9: force_page
        do_reset();
        @(negedge clk);
        force_page = 1'b1;
        @(negedge clk);
        chk(paged_in, 1'b1, "R9 force");
        force_page = 1'b0;

        // R8: page-out fetch
        @(negedge clk);
        addr = 16'h007C; m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk(paged_in, 1'b1, "R8 held during fetch");
        m1_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; addr = 16'h8000;
        @(negedge clk);
        chk(paged_in, 1'b0, "R8 cleared after fetch");
        set_paged();
        mread(16'h007C, 8'h00);
        chk(paged_in, 1'b1, "R8 plain read ignored");

        // R10: downstream A15 sweep
        for (int p = 0; p < 2; p++) begin
            for (int dn = 0; dn < 2; dn++) begin
                for (int q = 0; q < 4; q++) begin
                    logic exp;
                    do_reset();
                    if (p == 1) set_paged();
                    @(negedge clk);
                    deny_a15 = dn[0];
                    addr = {q[1:0], 14'h0123};
                    #1;
                    exp = q[1] || (q == 0 && (p == 1 || dn == 1));
                    chk(a15_down, exp, "R10");
                    deny_a15 = 1'b0;
                    addr = 16'h8000;
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule